// File: doc/BRIEF.md
# Auto-Incrementing Converter Channel Sequencer

This block keeps the control settings of a four-input analog converter front end and decides which input channel the next conversion samples. A bus slave, not part of this block, passes on the byte that follows the address byte of a write transfer as a single-cycle write pulse with its data. The converter signals each finished conversion with a single-cycle done strobe. From these two events the block keeps a channel index, an input-mode code, an analog-output enable and an auto-increment flag. It also offers a readback of the whole control byte.

The input mode splits the four inputs into single-ended, differential or mixed channel sets. The mode sets how many channels exist. A channel request that names a channel beyond that count is clamped to the last channel the mode has. With auto-increment on, every finished conversion moves the index to the next channel. After the last channel of the mode, the index goes back to channel 0. The analog-output enable also tells the conversion clock source to keep running, and it drives the enable of the analog output's tri-state driver.

Top module: `chan_seq_top`

## Requirements
- R1: A synchronous active-high reset clears the whole control state. After it, the channel is 0, the mode is 0, the output enable, the clock-run flag and the tri-state enable are all 0, and the readback is 8'h00.
- R2: A write stores the mode from data bits 5:4, the analog-output enable from bit 6 and the auto-increment flag from bit 2. The new values show at the outputs in the cycle after the write pulse.
- R3: Bits 7 and 3 of the readback always read 0, whatever value was written to them.
- R4: A write loads the channel at once, clamped to the last channel of the newly written mode. Mode 0 allows channels 0..3, modes 1 and 2 allow 0..2, and mode 3 allows 0..1.
- R5: With auto-increment set, each conversion-done pulse moves the channel up by one, as long as the channel is below the last channel of the mode.
- R6: With auto-increment set, a conversion-done pulse while the channel sits on the last channel of the mode returns it to channel 0.
- R7: With auto-increment clear, a conversion-done pulse leaves the channel unchanged.
- R8: When a write and a conversion-done pulse arrive in the same cycle, only the write takes effect.
- R9: The clock-run flag and the tri-state output enable both equal the stored analog-output enable bit.
- R10: The readback returns the output enable in bit 6, the mode in bits 5:4, auto-increment in bit 2 and the current channel, including any increments, in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ctl_wr | input | 1 | Single-cycle pulse: a control byte is written |
| ctl_wdata | input | 8 | Control byte written with the pulse |
| conv_done | input | 1 | Single-cycle pulse: a conversion has finished |
| chan_idx | output | 2 | Channel used by the next conversion |
| in_mode | output | 2 | Stored input-mode code |
| osc_run | output | 1 | Conversion clock source must keep running |
| aout_oe | output | 1 | Tri-state enable of the analog output (low = high impedance) |
| ctl_rdata | output | 8 | Control register readback |

## Verification
The bench writes every mode with every channel request, with the reserved bits set and clear. This catches a clamp that uses the old mode instead of the new one, or one that passes an out-of-range channel through, and a design that stores reserved bits would show them in the readback. Long runs of done pulses in modes 0 and 3 check the wrap point, where a design that wraps at a fixed count of four would produce channel 2 or 3 in the two-channel mode. Done pulses with auto-increment off, and done pulses that coincide with a write, catch a design that steps anyway or lets the increment override the freshly loaded channel.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
  localparam int CTL_W  = 8;
  localparam int CHAN_W = 2;

  typedef enum logic [1:0] {
    MODE_SE4   = 2'd0,
    MODE_DIFF3 = 2'd1,
    MODE_MIX3  = 2'd2,
    MODE_DIFF2 = 2'd3
  } in_mode_e;

  // Highest channel number that exists in a given input mode.
  function automatic logic [CHAN_W-1:0] last_chan(input in_mode_e m);
    case (m)
      MODE_SE4:   last_chan = 2'd3;
      MODE_DIFF3: last_chan = 2'd2;
      MODE_MIX3:  last_chan = 2'd2;
      default:    last_chan = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/chseq_ctl_reg.sv
module chseq_ctl_reg
  import chseq_pkg::*;
#(
  parameter int OE_BIT   = 6,
  parameter int MODE_LSB = 4,
  parameter int AINC_BIT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output in_mode_e         mode_q,
  output logic             oe_q,
  output logic             ainc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_SE4;
      oe_q   <= 1'b0;
      ainc_q <= 1'b0;
    end else if (wr) begin
      mode_q <= in_mode_e'(wdata[MODE_LSB +: 2]);
      oe_q   <= wdata[OE_BIT];
      ainc_q <= wdata[AINC_BIT];
    end
  end

  AST_WR_OE: assert property (@(posedge clk) disable iff (rst)
    wr |=> oe_q == $past(wdata[OE_BIT])) else $error("oe not loaded"); // R2
  AST_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(mode_q) && $stable(ainc_q)) else $error("cfg moved"); // R2
endmodule

// File: rtl/chseq_chan_ctr.sv
module chseq_chan_ctr
  import chseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CHAN_W-1:0] req_chan,
  input  in_mode_e          wr_mode,
  input  logic              done,
  input  logic              ainc,
  input  in_mode_e          cur_mode,
  output logic [CHAN_W-1:0] chan_q
);
  logic [CHAN_W-1:0] wr_last, cur_last, clamped, stepped;

  always_comb begin
    wr_last  = last_chan(wr_mode);
    cur_last = last_chan(cur_mode);
    clamped  = (req_chan > wr_last) ? wr_last : req_chan;
    stepped  = (chan_q >= cur_last) ? '0 : chan_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)               chan_q <= '0;
    else if (wr)           chan_q <= clamped;
    else if (done && ainc) chan_q <= stepped;
  end

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (rst)
    chan_q <= last_chan(cur_mode)) else $error("chan out of range"); // R4
  AST_STEP: assert property (@(posedge clk) disable iff (rst)
    !wr && done && ainc && chan_q < last_chan(cur_mode) |=> chan_q == $past(chan_q) + 1'b1)
    else $error("no step"); // R5
  AST_WRAP: assert property (@(posedge clk) disable iff (rst)
    !wr && done && ainc && chan_q == last_chan(cur_mode) |=> chan_q == '0)
    else $error("no wrap"); // R6
  AST_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    !wr && !ainc |=> $stable(chan_q)) else $error("stepped without ainc"); // R7
endmodule

// File: rtl/chan_seq_top.sv
module chan_seq_top
  import chseq_pkg::*;
#(
  parameter int OE_BIT   = 6,
  parameter int MODE_LSB = 4,
  parameter int AINC_BIT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       conv_done,
  output logic [1:0] chan_idx,
  output logic [1:0] in_mode,
  output logic       osc_run,
  output logic       aout_oe,
  output logic [7:0] ctl_rdata
);
  in_mode_e mode_q;
  logic     oe_q, ainc_q;

  chseq_ctl_reg #(.OE_BIT(OE_BIT), .MODE_LSB(MODE_LSB), .AINC_BIT(AINC_BIT)) u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata),
    .mode_q(mode_q), .oe_q(oe_q), .ainc_q(ainc_q)
  );

  chseq_chan_ctr u_ctr (
    .clk(clk), .rst(rst), .wr(ctl_wr),
    .req_chan(ctl_wdata[CHAN_W-1:0]),
    .wr_mode(in_mode_e'(ctl_wdata[MODE_LSB +: 2])),
    .done(conv_done), .ainc(ainc_q), .cur_mode(mode_q),
    .chan_q(chan_idx)
  );

  always_comb begin
    in_mode   = mode_q;
    osc_run   = oe_q;
    aout_oe   = oe_q;
    ctl_rdata = '0;
    ctl_rdata[OE_BIT]          = oe_q;
    ctl_rdata[MODE_LSB +: 2]   = mode_q;
    ctl_rdata[AINC_BIT]        = ainc_q;
    ctl_rdata[CHAN_W-1:0]      = chan_idx;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> !ctl_rdata[7] && !ctl_rdata[3]) else $error("reserved set"); // R3
  AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
    ctl_wr && conv_done && ctl_wdata[1:0] == 2'd0 |=> chan_idx == 2'd0)
    else $error("done beat write"); // R8
  AST_OE_PINS: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> aout_oe == $past(ctl_wdata[6]) && osc_run == $past(ctl_wdata[6]))
    else $error("oe pins"); // R9
endmodule

// File: tb/chan_seq_top_tb.sv
module chan_seq_top_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       conv_done = 1'b0;
  logic [1:0] chan_idx, in_mode;
  logic       osc_run, aout_oe;
  logic [7:0] ctl_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  string tag  = "R1";

  // Reference model state
  int m_chan = 0, m_mode = 0, m_oe = 0, m_ainc = 0;

  always #10 clk = ~clk;

  chan_seq_top u_dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .conv_done(conv_done), .chan_idx(chan_idx), .in_mode(in_mode),
    .osc_run(osc_run), .aout_oe(aout_oe), .ctl_rdata(ctl_rdata)
  );

  function automatic int top_of(int mode);
    if (mode == 0) return 3;
    if (mode == 3) return 1;
    return 2;
  endfunction

  task automatic check(string t, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int rd;
    rd = m_oe * 64 + m_mode * 16 + m_ainc * 4 + m_chan;
    check({tag, " chan"}, int'(chan_idx), m_chan);
    check({tag, " mode"}, int'(in_mode), m_mode);
    check({tag, " R9 osc_run"}, int'(osc_run), m_oe);
    check({tag, " R9 aout_oe"}, int'(aout_oe), m_oe);
    check({tag, " R10 readback"}, int'(ctl_rdata), rd);
  endtask

  // One clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(bit w, logic [7:0] d, bit c);
    int req;
    ctl_wr = w; ctl_wdata = d; conv_done = c;
    @(posedge clk);
    if (rst) begin
      m_chan = 0; m_mode = 0; m_oe = 0; m_ainc = 0;
    end else if (w) begin
      m_mode = int'(d[5:4]);
      m_oe   = int'(d[6]);
      m_ainc = int'(d[2]);
      req    = int'(d[1:0]);
      m_chan = (req > top_of(m_mode)) ? top_of(m_mode) : req;
    end else if (c && m_ainc == 1) begin
      m_chan = (m_chan >= top_of(m_mode)) ? 0 : m_chan + 1;
    end
    @(negedge clk);
    ctl_wr = 1'b0; conv_done = 1'b0;
    compare_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    // R1: reset with junk on inputs
    tag = "R1";
    step(1'b1, 8'hFF, 1'b1);
    step(1'b0, 8'h00, 1'b1);
    rst = 1'b0;
    check("R1 readback zero", int'(ctl_rdata), 0);
    check("R1 aout_oe low", int'(aout_oe), 0);

    // R2/R3/R4: every mode with every request, reserved bits toggled
    tag = "R4";
    for (int md = 0; md < 4; md++) begin
      for (int rq = 0; rq < 4; rq++) begin
        logic [7:0] d;
        d = 8'((md << 4) | rq);
        if (rq[0]) d = d | 8'h88;
        if (md[0]) d = d | 8'h40;
        if (rq[1]) d = d | 8'h04;
        step(1'b1, d, 1'b0);
        check("R3 bit7", int'(ctl_rdata[7]), 0);
        check("R3 bit3", int'(ctl_rdata[3]), 0);
        check("R2 mode stored", int'(in_mode), md);
      end
    end

    // R5/R6: mode 0, ainc, start at 1, walk past the wrap
    tag = "R5";
    step(1'b1, 8'h45, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b0, 8'h00, 1'b1);
    tag = "R6";
    step(1'b1, 8'h37, 1'b0);   // mode 3, ainc, request 3 -> clamp to 1
    check("R4 clamp mode3", int'(chan_idx), 1);
    step(1'b0, 8'h00, 1'b1);
    check("R6 wrap mode3", int'(chan_idx), 0);
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1);
    step(1'b1, 8'h16, 1'b0);   // mode 1, ainc, chan 2
    step(1'b0, 8'h00, 1'b1);
    check("R6 wrap mode1", int'(chan_idx), 0);
    step(1'b1, 8'h26, 1'b0);   // mode 2
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 8'h00, i[0]);
    end

    // R7: done with ainc clear
    tag = "R7";
    step(1'b1, 8'h02, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b1);
    check("R7 no step", int'(chan_idx), 2);

    // R8: write and done together
    tag = "R8";
    step(1'b1, 8'h44, 1'b0);
    step(1'b1, 8'h05, 1'b1);
    check("R8 write wins", int'(chan_idx), 1);
    step(1'b1, 8'h37, 1'b1);
    check("R8 write wins clamp", int'(chan_idx), 1);

    // R10: readback follows increments
    tag = "R10";
    step(1'b1, 8'h44, 1'b0);
    step(1'b0, 8'h00, 1'b1);
    step(1'b0, 8'h00, 1'b1);
    check("R10 readback chan", int'(ctl_rdata), 8'h46);

    // R1 again: reset mid-run
    tag = "R1";
    rst = 1'b1;
    step(1'b0, 8'h00, 1'b1);
    rst = 1'b0;
    check("R1 reset mid-run", int'(ctl_rdata), 0);
    step(1'b0, 8'h00, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule